// File: doc/BRIEF.md
# Interrupting Character Input Port

This block is a one-byte receive port that sits on a simple processor bus. An external character source presents an 8-bit code together with a one-cycle valid strobe. The port keeps that code in a holding register and raises an interrupt request. The request feeds input 2 of an external seven-input priority encoder, so the processor services it at interrupt level 2.

The processor takes the byte by reading the port. The port is selected when the bus cycle strobe is active and the top address line (bit 23, which places the register at 0x800000) is high. That single read does two things. It returns the code on the low eight data lines, and it acknowledges the interrupt. No separate status or clear register exists.

An acknowledge pulse answers every read one cycle after the request is seen. Only one byte is held. A newer arrival replaces an unread one. When an arrival and a read fall in the same cycle, the arrival wins the request state, so the new byte is never lost.

Top module: `char_in_port`

## Requirements
- R1: While reset is held and after it is released, irq, bus_ack and all bus_dout bits are 0, and the first read after reset returns 0x0000.
- R2: A cycle with src_valid high stores src_data and drives irq to 1 from the next clock edge.
- R3: Once set, irq stays at 1 through any number of cycles in which the port is not read.
- R4: A read request (bus_as=1, bus_addr_sel=1, bus_rd=1) while bus_ack is 0 produces bus_ack=1 for exactly one cycle, starting at the next clock edge.
- R5: During the acknowledge cycle, bus_dout[7:0] carries the held character and bus_dout[15:8] is 0. Outside that cycle, bus_dout is 0.
- R6: A read with no arrival in the same cycle clears irq at the same edge that raises bus_ack.
- R7: A second arrival before any read replaces the held byte, and irq stays at 1.
- R8: When a read and an arrival share a cycle, the read returns the older byte, the newer byte is held, and irq stays at 1.
- R9: A bus cycle with bus_addr_sel=0, or with bus_as=0, is not acknowledged and leaves irq and the held byte unchanged.
- R10: A write cycle (bus_as=1, bus_addr_sel=1, bus_rd=0) is not acknowledged and leaves irq and the held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_as | input | 1 | Bus cycle strobe |
| bus_addr_sel | input | 1 | Address bit 23; high selects this port |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_dout | output | 16 | Read data; character on bits 7:0 |
| bus_ack | output | 1 | One-cycle acknowledge of a read |
| src_valid | input | 1 | One-cycle strobe marking a new character |
| src_data | input | 8 | Character code from the source |
| irq | output | 1 | Interrupt request to the priority encoder input 2 |

## Verification
The receive path is exercised with the codes 0x00, 0xFF, 0xA5 and 0x41. An all-zero code shows that irq is driven by the arrival and not by the data value. The all-ones code exposes any leakage into the upper bus byte, and the alternating code catches swapped bit lanes. Back-to-back arrivals separate the overwrite rule from a dropped update, and a read coinciding with an arrival separates "arrival wins" from "clear wins". Cycles that are deselected, that have no strobe, or that are writes are each placed between an arrival and the final read, which shows that none of them acknowledges the cycle or consumes the byte.

// File: rtl/inport_pkg.sv
package inport_pkg;

  // Kind of bus access the port sees in a given cycle
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/inport_rst_sync.sv
module inport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/inport_hold.sv
module inport_hold #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  input  logic              rd_take,
  output logic [CHAR_W-1:0] hold_data,
  output logic              irq
);

  logic [CHAR_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              irq_q, irq_d;

  // Next state: an arrival always wins over a clearing read
  always_comb begin
    hold_en = src_valid;
    hold_d  = src_data;
    if (src_valid) begin
      irq_d = 1'b1;
    end else if (rd_take) begin
      irq_d = 1'b0;
    end else begin
      irq_d = irq_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      if (hold_en) begin
        hold_q <= hold_d;
      end
    end
  end

  assign hold_data = hold_q;
  assign irq       = irq_q;

  // R2
  arrival_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> (irq_q && hold_q == $past(src_data)));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !src_valid) |=> !irq_q);

  // R3
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !rd_take) |=> irq_q);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> $stable(hold_q));

endmodule

// File: rtl/inport_bus_ctl.sv
module inport_bus_ctl
  import inport_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as,
  input  logic              bus_addr_sel,
  input  logic              bus_rd,
  input  logic [CHAR_W-1:0] hold_data,
  output logic              rd_take,
  output logic              ack,
  output logic [BUS_W-1:0]  rdata
);

  localparam int unsigned PAD_W = BUS_W - CHAR_W;

  acc_kind_e         kind;
  logic              ack_q, ack_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              data_en;
  logic [CHAR_W-1:0] lane;

  // Access decode
  always_comb begin
    if (!(bus_as && bus_addr_sel)) begin
      kind = ACC_NONE;
    end else if (bus_rd) begin
      kind = ACC_READ;
    end else begin
      kind = ACC_WRITE;
    end
  end

  // A read is taken once; the acknowledge cycle blocks a second take
  always_comb begin
    rd_take = (kind == ACC_READ) && !ack_q;
    ack_d   = rd_take;
    data_en = rd_take;
    data_d  = hold_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (data_en) begin
        data_q <= data_d;
      end
    end
  end

  assign ack  = ack_q;
  assign lane = ack_q ? data_q : '0;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, lane};
    end else begin : g_nopad
      assign rdata = lane;
    end
  endgenerate

  // R4
  ack_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_addr_sel && bus_rd && !ack_q) |=> ack_q);

  // R4
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

  // R9
  no_ack_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_as && bus_addr_sel) && !ack_q) |=> !ack_q);

  // R10
  no_ack_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && !bus_rd && !ack_q) |=> !ack_q);

endmodule

// File: rtl/char_in_port.sv
module char_in_port #(
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_as,
  input  logic              bus_addr_sel,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_ack,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  output logic              irq
);

  logic              rst_n_int;
  logic              rd_take;
  logic [CHAR_W-1:0] hold_data;

  inport_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  inport_hold #(
    .CHAR_W (CHAR_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .src_valid (src_valid),
    .src_data  (src_data),
    .rd_take   (rd_take),
    .hold_data (hold_data),
    .irq       (irq)
  );

  inport_bus_ctl #(
    .CHAR_W (CHAR_W),
    .BUS_W  (BUS_W)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .bus_as       (bus_as),
    .bus_addr_sel (bus_addr_sel),
    .bus_rd       (bus_rd),
    .hold_data    (hold_data),
    .rd_take      (rd_take),
    .ack          (bus_ack),
    .rdata        (bus_dout)
  );

  // R5
  read_returns_held_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(bus_ack) |-> (bus_dout[CHAR_W-1:0] == $past(hold_data)));

  // R5
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !bus_ack |-> (bus_dout == '0));

endmodule

// File: tb/tb_char_in_port.sv
module tb_char_in_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_as, bus_addr_sel, bus_rd;
  logic [15:0] bus_dout;
  logic        bus_ack;
  logic        src_valid;
  logic [7:0]  src_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_in_port dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_as       (bus_as),
    .bus_addr_sel (bus_addr_sel),
    .bus_rd       (bus_rd),
    .bus_dout     (bus_dout),
    .bus_ack      (bus_ack),
    .src_valid    (src_valid),
    .src_data     (src_data),
    .irq          (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive an arrival for one cycle; returns at the negedge after the capture edge
  task automatic push(input logic [7:0] code);
    src_valid = 1'b1;
    src_data  = code;
    @(negedge clk);
    src_valid = 1'b0;
    src_data  = '0;
  endtask

  // issue a read; returns sampled data/ack at the acknowledge cycle
  task automatic read_port(output logic [15:0] got, output logic acked);
    bus_as = 1'b1; bus_addr_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    got   = bus_dout;
    acked = bus_ack;
    bus_as = 1'b0; bus_addr_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic a;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {15'd0, irq}, 16'd0);
    check("R1 ack in reset", {15'd0, bus_ack}, 16'd0);
    check("R1 dout in reset", bus_dout, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    read_port(d, a);
    check("R4 ack on first read", {15'd0, a}, 16'd1);
    check("R1 first read value", d, 16'h0000);
    @(negedge clk);
  endtask

  task automatic t_basic(input logic [7:0] code);
    logic [15:0] d; logic a;
    push(code);
    check("R2 irq after arrival", {15'd0, irq}, 16'd1);
    repeat (3) @(negedge clk);
    check("R3 irq held while unread", {15'd0, irq}, 16'd1);
    read_port(d, a);
    check("R4 ack one cycle after request", {15'd0, a}, 16'd1);
    check("R5 read data on low lanes", d, {8'h00, code});
    check("R6 irq cleared by read", {15'd0, irq}, 16'd0);
    @(negedge clk);
    check("R4 ack lasts one cycle", {15'd0, bus_ack}, 16'd0);
    check("R5 bus idle zero", bus_dout, 16'h0000);
  endtask

  task automatic t_overwrite();
    logic [15:0] d; logic a;
    push(8'h31);
    push(8'h32);
    check("R7 irq stays after overwrite", {15'd0, irq}, 16'd1);
    read_port(d, a);
    check("R7 newer byte returned", d, 16'h0032);
    check("R6 irq cleared", {15'd0, irq}, 16'd0);
    @(negedge clk);
  endtask

  task automatic t_collision();
    logic [15:0] d; logic a;
    push(8'h51);
    bus_as = 1'b1; bus_addr_sel = 1'b1; bus_rd = 1'b1;
    src_valid = 1'b1; src_data = 8'h52;
    @(negedge clk);
    d = bus_dout; a = bus_ack;
    bus_as = 1'b0; bus_addr_sel = 1'b0; bus_rd = 1'b0;
    src_valid = 1'b0; src_data = '0;
    check("R8 ack on colliding read", {15'd0, a}, 16'd1);
    check("R8 older byte returned", d, 16'h0051);
    check("R8 irq kept by arrival", {15'd0, irq}, 16'd1);
    @(negedge clk);
    read_port(d, a);
    check("R8 newer byte kept", d, 16'h0052);
    check("R6 irq cleared after second read", {15'd0, irq}, 16'd0);
    @(negedge clk);
  endtask

  task automatic t_unselected();
    logic [15:0] d; logic a;
    push(8'h61);
    bus_as = 1'b1; bus_addr_sel = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    check("R9 no ack when deselected", {15'd0, bus_ack}, 16'd0);
    @(negedge clk);
    check("R9 irq kept when deselected", {15'd0, irq}, 16'd1);
    bus_as = 1'b0; bus_addr_sel = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    check("R9 no ack without strobe", {15'd0, bus_ack}, 16'd0);
    @(negedge clk);
    check("R9 irq kept without strobe", {15'd0, irq}, 16'd1);
    bus_as = 1'b0; bus_addr_sel = 1'b0; bus_rd = 1'b0;
    read_port(d, a);
    check("R9 byte intact", d, 16'h0061);
    @(negedge clk);
  endtask

  task automatic t_write();
    logic [15:0] d; logic a;
    push(8'h71);
    bus_as = 1'b1; bus_addr_sel = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    check("R10 no ack on write", {15'd0, bus_ack}, 16'd0);
    @(negedge clk);
    check("R10 irq kept on write", {15'd0, irq}, 16'd1);
    bus_as = 1'b0; bus_addr_sel = 1'b0;
    read_port(d, a);
    check("R10 byte intact after write", d, 16'h0071);
    check("R10 read still acked", {15'd0, a}, 16'd1);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_as = 1'b0; bus_addr_sel = 1'b0; bus_rd = 1'b0;
    src_valid = 1'b0; src_data = '0;
    @(negedge clk);
    t_reset();
    t_basic(8'h41);
    t_basic(8'h00);
    t_basic(8'hFF);
    t_basic(8'hA5);
    t_overwrite();
    t_collision();
    t_unselected();
    t_write();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule